// File: doc/BRIEF.md
# CAN Sleep Handshake and Configuration Write Guard

This block sits next to a CAN protocol engine and owns two pieces of control. The first is the low-power handshake. Software asks for sleep through a request bit. The block enters sleep only when the engine reports no reception and no transmission. It shows that it has entered sleep through an acknowledge status bit, and while asleep it removes the engine's clock enable. Sleep ends in one of two ways: software withdraws the request, or bus activity appears. Bus activity also raises a one-cycle wakeup interrupt when wakeup is enabled.

The second piece is the configuration write guard. The engine's configuration bytes are the control byte, two bit-timing bytes, an acceptance-mode byte, four acceptance bytes and four mask bytes. They accept writes only while a soft-reset bit is set. The error counters kept by the engine can be read through the same port but cannot be changed from it. When the host enters stop mode, the transmit pin is held recessive whatever the engine drives.

The sleep state machine has three states:
- `SLP_AWAKE`: running.
- `SLP_PENDING`: a request is waiting for the bus to go idle.
- `SLP_ASLEEP`: clock gated, acknowledge set.

Its transitions are:
- AWAKE→ASLEEP: request set while idle.
- AWAKE→PENDING: request set while busy.
- PENDING→AWAKE: request withdrawn.
- PENDING→ASLEEP: first idle cycle with the request still set.
- ASLEEP→AWAKE on activity: interrupt if enabled, request bit cleared by hardware.
- ASLEEP→AWAKE on request withdrawn: no interrupt.

Activity takes priority over a withdrawn request.

Top module: `can_sleep_guard`

## Requirements
- R1: After reset the control byte (address 0) reads 0x01, with soft reset at bit 0 set and all other bits clear. The clock enable is 1, the wakeup interrupt is 0, and every configuration byte reads 0.
- R2: Writing the request bit (bit 1 of address 0) while `rx_busy` and `tx_busy` are both low sets the acknowledge bit (bit 2, read-only) and drops `clk_en`. Both changes appear on the second rising edge after the write is presented, that is, one edge after the edge that stores the write.
- R3: While `rx_busy` or `tx_busy` is high, acknowledge stays 0 and `clk_en` stays 1. The pending request is honoured on the first edge that samples both busy inputs low, provided the request bit is still set. If the request was withdrawn first, no sleep happens.
- R4: Clearing the request bit while asleep clears acknowledge and restores `clk_en` one edge after the write is stored, without a wakeup interrupt.
- R5: Bus activity while asleep clears acknowledge, restores `clk_en` and clears the request bit on the same edge. `wake_irq` is high for exactly the following cycle if and only if the wake-enable bit (bit 3 of address 0) is set.
- R6: `wake_irq` is never raised unless the block was asleep in the cycle before.
- R7: Writes to the configuration bytes are ignored while soft reset is 0 and take effect on the write edge while it is 1. The configuration bytes are addresses 1 (control), 2 and 3 (timing), 4 (acceptance mode), 8 to 11 (acceptance) and 12 to 15 (masks).
- R8: Address 16 reads `rx_err_cnt` and address 17 reads `tx_err_cnt`. Writes to these addresses change nothing.
- R9: The soft-reset, request and wake-enable bits of address 0 are writable whatever the soft-reset value.
- R10: While `stop_mode` is 1, `tx_pin` is 1 (recessive) in the same cycle. Otherwise `tx_pin` equals `eng_tx`.
- R11: Reads of unmapped addresses return 0, and writes to them change no readable byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational from `rd_addr` |
| rx_busy | input | 1 | Engine is receiving |
| tx_busy | input | 1 | Engine is transmitting |
| rx_err_cnt | input | DW | Engine receive error counter |
| tx_err_cnt | input | DW | Engine transmit error counter |
| eng_tx | input | 1 | Engine transmit bit |
| stop_mode | input | 1 | Host stop mode |
| tx_pin | output | 1 | Transmit pin after override |
| clk_en | output | 1 | Engine clock enable |
| wake_irq | output | 1 | Wakeup interrupt pulse |
| cfg_ctrl | output | DW | Control configuration byte |
| cfg_time0 | output | DW | Bit-timing byte 0 |
| cfg_time1 | output | DW | Bit-timing byte 1 |
| cfg_acc_mode | output | DW | Acceptance mode byte |
| cfg_acc | output | NFILT*DW | Acceptance bytes, byte i at bits i*DW |
| cfg_mask | output | NFILT*DW | Mask bytes, byte i at bits i*DW |

## Verification
The bench sweeps the busy window length from one to four cycles on both the receive and transmit busy inputs. A design that slept on a busy bus, or that waited an extra cycle after the bus went idle, fails at the exact sampled cycle. It also withdraws a pending request before the bus goes idle; a design that kept a stale request would fall asleep there. The full address space is swept with the guard open and closed, which catches a lock that covers too few or too many addresses and error counters that take writes. Wakeup is tried with the interrupt enabled and disabled, and with the request withdrawn instead. A design that interrupts on the wrong exit, or that leaves the request set and falls straight back asleep, fails there.

// File: rtl/canpm_pkg.sv
package canpm_pkg;

    typedef enum logic [1:0] {
        SLP_AWAKE   = 2'd0,
        SLP_PENDING = 2'd1,
        SLP_ASLEEP  = 2'd2
    } slp_state_e;

    // address map (byte addresses)
    localparam int ADDR_MCTL      = 0;
    localparam int ADDR_FILT_BASE = 8;
    localparam int NUM_FIXED_CFG  = 4;   // control, timing0, timing1, acceptance mode

    // control byte bit positions
    localparam int BIT_SRST = 0;
    localparam int BIT_REQ  = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_WAKE = 3;

    // address of configuration slot i: fixed bytes at 1.., filter bytes from the filter base
    function automatic int cfg_addr(input int i);
        return (i < NUM_FIXED_CFG) ? (i + 1) : (ADDR_FILT_BASE + i - NUM_FIXED_CFG);
    endfunction

endpackage

// File: rtl/canpm_lockreg.sv
module canpm_lockreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          unlock,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (we && unlock)
            q <= d;
    end
endmodule

// File: rtl/canpm_regfile.sv
module canpm_regfile
    import canpm_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int NFILT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                slp_ack,
    input  logic                req_clr,
    input  logic [DW-1:0]       rx_err_cnt,
    input  logic [DW-1:0]       tx_err_cnt,
    output logic                soft_rst,
    output logic                slp_req,
    output logic                wake_en,
    output logic [DW-1:0]       cfg_ctrl,
    output logic [DW-1:0]       cfg_time0,
    output logic [DW-1:0]       cfg_time1,
    output logic [DW-1:0]       cfg_acc_mode,
    output logic [NFILT*DW-1:0] cfg_acc,
    output logic [NFILT*DW-1:0] cfg_mask
);
    localparam int NCFG      = NUM_FIXED_CFG + 2 * NFILT;
    localparam int ADDR_RXE  = ADDR_FILT_BASE + 2 * NFILT;
    localparam int ADDR_TXE  = ADDR_RXE + 1;

    logic [DW-1:0] cfg_q [NCFG];
    logic          mctl_we;

    assign mctl_we = wr_en && (wr_addr == AW'(ADDR_MCTL));

    // control byte: always writable; hardware clears the request on an activity wakeup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_rst <= 1'b1;
            slp_req  <= 1'b0;
            wake_en  <= 1'b0;
        end else begin
            if (mctl_we) begin
                soft_rst <= wr_data[BIT_SRST];
                slp_req  <= wr_data[BIT_REQ];
                wake_en  <= wr_data[BIT_WAKE];
            end
            if (req_clr)
                slp_req <= 1'b0;
        end
    end

    // lockable configuration bytes
    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
        localparam int A = cfg_addr(i);
        canpm_lockreg #(.DW(DW)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && (wr_addr == AW'(A))),
            .unlock (soft_rst),
            .d      (wr_data),
            .q      (cfg_q[i])
        );
    end

    assign cfg_ctrl     = cfg_q[0];
    assign cfg_time0    = cfg_q[1];
    assign cfg_time1    = cfg_q[2];
    assign cfg_acc_mode = cfg_q[3];

    for (genvar i = 0; i < NFILT; i++) begin : g_filt
        assign cfg_acc[i*DW +: DW]  = cfg_q[NUM_FIXED_CFG + i];
        assign cfg_mask[i*DW +: DW] = cfg_q[NUM_FIXED_CFG + NFILT + i];
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_MCTL)) begin
            rd_data[BIT_SRST] = soft_rst;
            rd_data[BIT_REQ]  = slp_req;
            rd_data[BIT_ACK]  = slp_ack;
            rd_data[BIT_WAKE] = wake_en;
        end else if (rd_addr == AW'(ADDR_RXE)) begin
            rd_data = rx_err_cnt;
        end else if (rd_addr == AW'(ADDR_TXE)) begin
            rd_data = tx_err_cnt;
        end else begin
            for (int i = 0; i < NCFG; i++)
                if (rd_addr == AW'(cfg_addr(i)))
                    rd_data = cfg_q[i];
        end
    end
endmodule

// File: rtl/canpm_sleep_fsm.sv
module canpm_sleep_fsm
    import canpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slp_req,
    input  logic wake_en,
    input  logic bus_busy,
    output logic slp_ack,
    output logic clk_en,
    output logic req_clr,
    output logic wake_irq
);
    slp_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SLP_AWAKE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLP_AWAKE: begin
                if (slp_req)
                    state_d = bus_busy ? SLP_PENDING : SLP_ASLEEP;
            end
            SLP_PENDING: begin
                if (!slp_req)
                    state_d = SLP_AWAKE;
                else if (!bus_busy)
                    state_d = SLP_ASLEEP;
            end
            SLP_ASLEEP: begin
                if (bus_busy || !slp_req)
                    state_d = SLP_AWAKE;
            end
            default: state_d = SLP_AWAKE;
        endcase
    end

    // outputs
    always_comb begin
        slp_ack = (state_q == SLP_ASLEEP);
        clk_en  = (state_q != SLP_ASLEEP);
        req_clr = (state_q == SLP_ASLEEP) && bus_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_irq <= 1'b0;
        else
            wake_irq <= (state_q == SLP_ASLEEP) && bus_busy && wake_en;
    end
endmodule

// File: rtl/canpm_txgate.sv
module canpm_txgate (
    input  logic eng_tx,
    input  logic stop_mode,
    output logic tx_pin
);
    localparam logic RECESSIVE = 1'b1;
    assign tx_pin = stop_mode ? RECESSIVE : eng_tx;
endmodule

// File: rtl/can_sleep_guard.sv
module can_sleep_guard #(
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int NFILT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                rx_busy,
    input  logic                tx_busy,
    input  logic [DW-1:0]       rx_err_cnt,
    input  logic [DW-1:0]       tx_err_cnt,
    input  logic                eng_tx,
    input  logic                stop_mode,
    output logic                tx_pin,
    output logic                clk_en,
    output logic                wake_irq,
    output logic [DW-1:0]       cfg_ctrl,
    output logic [DW-1:0]       cfg_time0,
    output logic [DW-1:0]       cfg_time1,
    output logic [DW-1:0]       cfg_acc_mode,
    output logic [NFILT*DW-1:0] cfg_acc,
    output logic [NFILT*DW-1:0] cfg_mask
);
    logic soft_rst, slp_req, wake_en, slp_ack, req_clr, bus_busy;

    assign bus_busy = rx_busy | tx_busy;

    canpm_regfile #(.DW(DW), .AW(AW), .NFILT(NFILT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .slp_ack      (slp_ack),
        .req_clr      (req_clr),
        .rx_err_cnt   (rx_err_cnt),
        .tx_err_cnt   (tx_err_cnt),
        .soft_rst     (soft_rst),
        .slp_req      (slp_req),
        .wake_en      (wake_en),
        .cfg_ctrl     (cfg_ctrl),
        .cfg_time0    (cfg_time0),
        .cfg_time1    (cfg_time1),
        .cfg_acc_mode (cfg_acc_mode),
        .cfg_acc      (cfg_acc),
        .cfg_mask     (cfg_mask)
    );

    canpm_sleep_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .slp_req  (slp_req),
        .wake_en  (wake_en),
        .bus_busy (bus_busy),
        .slp_ack  (slp_ack),
        .clk_en   (clk_en),
        .req_clr  (req_clr),
        .wake_irq (wake_irq)
    );

    canpm_txgate u_tx (
        .eng_tx    (eng_tx),
        .stop_mode (stop_mode),
        .tx_pin    (tx_pin)
    );
endmodule

// File: rtl/canpm_checker.sv
module canpm_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_busy,
    input logic          tx_busy,
    input logic          wr_en,
    input logic          soft_rst,
    input logic          slp_req,
    input logic          slp_ack,
    input logic          wake_en,
    input logic          wake_irq,
    input logic          stop_mode,
    input logic          tx_pin,
    input logic [CW-1:0] cfg_all
);
    // R2 / R3: sleep is only entered from an idle bus with a live request
    a_r3_ack_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_ack) |-> !$past(rx_busy || tx_busy));
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_ack) |-> $past(slp_req));
    // R6: interrupt only after having been asleep
    a_r6_irq_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> $past(slp_ack));
    // R5: interrupt needs the enable, and the request has been cleared
    a_r5_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> ($past(wake_en) && !slp_req && !slp_ack));
    // R10: recessive in stop mode
    a_r10_stop_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> tx_pin);
    // R7: locked configuration does not move on a write
    a_r7_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> $stable(cfg_all));
endmodule

bind can_sleep_guard canpm_checker #(.CW(4*DW + 2*NFILT*DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_busy   (rx_busy),
    .tx_busy   (tx_busy),
    .wr_en     (wr_en),
    .soft_rst  (soft_rst),
    .slp_req   (slp_req),
    .slp_ack   (slp_ack),
    .wake_en   (wake_en),
    .wake_irq  (wake_irq),
    .stop_mode (stop_mode),
    .tx_pin    (tx_pin),
    .cfg_all   ({cfg_ctrl, cfg_time0, cfg_time1, cfg_acc_mode, cfg_acc, cfg_mask})
);

// File: tb/can_sleep_guard_bench.sv
module can_sleep_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        rx_busy, tx_busy, eng_tx, stop_mode;
    logic [7:0]  rx_err_cnt, tx_err_cnt;
    logic        tx_pin, clk_en, wake_irq;
    logic [7:0]  cfg_ctrl, cfg_time0, cfg_time1, cfg_acc_mode;
    logic [31:0] cfg_acc, cfg_mask;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [32];

    always #10 clk = ~clk;   // 50 MHz

    can_sleep_guard u_can_sleep_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_busy(rx_busy), .tx_busy(tx_busy),
        .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .eng_tx(eng_tx),
        .stop_mode(stop_mode), .tx_pin(tx_pin), .clk_en(clk_en), .wake_irq(wake_irq),
        .cfg_ctrl(cfg_ctrl), .cfg_time0(cfg_time0), .cfg_time1(cfg_time1),
        .cfg_acc_mode(cfg_acc_mode), .cfg_acc(cfg_acc), .cfg_mask(cfg_mask)
    );

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=hung exp=done");
        report();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rdchk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit is_cfg(input int a);
        return (a >= 1 && a <= 4) || (a >= 8 && a <= 15);
    endfunction

    function automatic logic [7:0] exp_read(input int a, input logic [7:0] mctl);
        if (a == 0)  return mctl;
        if (is_cfg(a)) return model[a];
        if (a == 16) return rx_err_cnt;
        if (a == 17) return tx_err_cnt;
        return 8'h00;
    endfunction

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        rx_busy = 1'b0; tx_busy = 1'b0; eng_tx = 1'b0; stop_mode = 1'b0;
        rx_err_cnt = 8'h3C; tx_err_cnt = 8'hA5;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdchk(5'd0, 8'h01, "R1 control byte");
        chk("R1 clk_en", {31'd0, clk_en}, 32'd1);
        chk("R1 wake_irq", {31'd0, wake_irq}, 32'd0);
        for (int a = 1; a < 16; a++)
            if (is_cfg(a)) rdchk(5'(a), 8'h00, "R1 cfg reset");

        // R7 / R8 / R9 / R11: address sweep with guard open then closed
        for (int s = 1; s >= 0; s--) begin
            wr(5'd0, 8'(s));                       // R9: control byte writable either way
            rdchk(5'd0, 8'(s), "R9 control byte");
            for (int a = 1; a < 32; a++) begin
                logic [7:0] pat;
                pat = 8'(a * 29 + s * 101 + 7);
                wr(5'(a), pat);
                if (is_cfg(a) && s == 1) model[a] = pat;
            end
            for (int a = 0; a < 32; a++)
                rdchk(5'(a), exp_read(a, 8'(s)),
                      (a == 16 || a == 17) ? "R8 error counter" :
                      is_cfg(a) ? "R7 cfg guard" : "R11 unmapped");
            chk("R7 cfg_time1 port", {24'd0, cfg_time1}, {24'd0, model[3]});
            chk("R7 cfg_mask port", cfg_mask, {model[15], model[14], model[13], model[12]});
        end
        wr(5'd0, 8'h01);

        // R2: idle request sleeps one edge after the stored write
        wr(5'd0, 8'h03);
        chk("R2 not yet asleep", {31'd0, clk_en}, 32'd1);
        @(negedge clk);
        chk("R2 clk_en gated", {31'd0, clk_en}, 32'd0);
        rdchk(5'd0, 8'h07, "R2 ack set");
        wr(5'd0, 8'h01);
        @(negedge clk);
        chk("R4 clk_en back", {31'd0, clk_en}, 32'd1);

        // R3: busy window sweep on each source
        for (int src = 0; src < 2; src++) begin
            for (int k = 1; k <= 4; k++) begin
                @(negedge clk);
                if (src == 0) rx_busy = 1'b1; else tx_busy = 1'b1;
                wr(5'd0, 8'h03);
                for (int j = 0; j < k; j++) begin
                    chk("R3 deferred while busy", {31'd0, clk_en}, 32'd1);
                    rdchk(5'd0, 8'h03, "R3 ack clear while busy");
                    @(negedge clk);
                end
                rx_busy = 1'b0; tx_busy = 1'b0;
                @(negedge clk);
                chk("R3 sleeps at first idle", {31'd0, clk_en}, 32'd0);
                chk("R6 no irq on entry", {31'd0, wake_irq}, 32'd0);
                // R4: withdraw request while asleep
                wr(5'd0, 8'h09);
                chk("R4 still asleep at write", {31'd0, clk_en}, 32'd0);
                @(negedge clk);
                chk("R4 awake", {31'd0, clk_en}, 32'd1);
                chk("R4 no irq", {31'd0, wake_irq}, 32'd0);
                rdchk(5'd0, 8'h09, "R4 ack clear");
            end
        end

        // R3 / R6: request withdrawn while pending never sleeps
        @(negedge clk);
        rx_busy = 1'b1;
        wr(5'd0, 8'h0B);
        @(negedge clk);
        wr(5'd0, 8'h09);
        rx_busy = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R3 cancelled request", {31'd0, clk_en}, 32'd1);
            chk("R6 no irq cancelled", {31'd0, wake_irq}, 32'd0);
        end

        // R6: activity while awake with wake enabled raises nothing
        for (int j = 0; j < 3; j++) begin
            tx_busy = (j != 1);
            @(negedge clk);
            chk("R6 no irq awake", {31'd0, wake_irq}, 32'd0);
        end
        tx_busy = 1'b0;

        // R5: activity wakeup with enable off and on
        for (int w = 0; w < 2; w++) begin
            wr(5'd0, 8'((w << 3) | 3));
            @(negedge clk);
            chk("R5 asleep", {31'd0, clk_en}, 32'd0);
            rx_busy = 1'b1;
            @(negedge clk);
            chk("R5 irq", {31'd0, wake_irq}, 32'(w));
            chk("R5 clk_en back", {31'd0, clk_en}, 32'd1);
            rdchk(5'd0, 8'((w << 3) | 1), "R5 request cleared");
            rx_busy = 1'b0;
            @(negedge clk);
            chk("R5 irq one cycle", {31'd0, wake_irq}, 32'd0);
            chk("R5 stays awake", {31'd0, clk_en}, 32'd1);
        end

        // R10: stop override, same cycle
        for (int c = 0; c < 4; c++) begin
            eng_tx = c[0]; stop_mode = c[1];
            #1;
            chk("R10 tx_pin", {31'd0, tx_pin}, {31'd0, (c[1] ? 1'b1 : c[0])});
            @(negedge clk);
        end
        stop_mode = 1'b0;

        report();
    end
endmodule